// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block is the host side of a byte-wide slave configuration link to an FPGA. After a start pulse it resets the target by pulling the program pin low. It waits for the target's done pin to drop, releases the program pin and waits for the target's init pin to rise. It then asserts chip select and write, and clocks out a fixed head of 0xFF fill bytes, the bitstream bytes taken from a valid/ready stream, and a fixed tail of 0x00 fill bytes. Each byte is launched on the data bus before a low-then-high pulse of the configuration clock.

When the tail has been sent, chip select and write are released. The loader then reports success if done rises, or an error if init falls. Every wait on a target pin has its own cycle limit. An error code tells which step stalled. The configuration clock is derived from the system clock with separate low and high phase lengths. The payload length is an input that is sampled at start.

Top module: `sp_cfg_loader`

## Requirements
- R1: After reset the loader is idle: prog_n_o, cs_n_o, wr_n_o and cclk_o are high, and busy_o, done_ok_o, err_o and s_ready_o are low.
- R2: A start pulse drives prog_n_o low until done_i is seen low, then holds prog_n_o high until init_i is seen high; cs_n_o and wr_n_o fall only after that and stay low for the whole data phase.
- R3: Each byte gives exactly one cclk_o pulse, low for CCLK_LO cycles then high for at least CCLK_HI cycles; d_o does not change while cclk_o stays high.
- R4: PAD_BYTES bytes of 0xFF precede the payload and PAD_BYTES bytes of 0x00 follow it.
- R5: The bus is bit-reversed: d_o[i] carries bit 7-i of the byte, so byte 0x01 sets only d_o[7] and byte 0xAA appears as d_o = 8'h55.
- R6: Exactly payload_len_i payload bytes are sent, in stream order; a length of zero goes straight from head fill to tail fill.
- R7: s_ready_o is high only in the payload phase while no byte is being clocked; each handshake sends one byte, and a low s_valid_i just holds cclk_o high.
- R8: After the tail, cs_n_o and wr_n_o return high. done_i high then gives done_ok_o. init_i low, seen before done_i, gives err_o with code 4. done_i wins when both happen in the same cycle.
- R9: A wait that lasts TMO_CYCLES cycles ends in err_o with code 1 (done never fell), 2 (init never rose) or 3 (neither done nor init fault after the tail). The first wait keeps busy_o high for exactly TMO_CYCLES cycles.
- R10: start_i is ignored while busy_o is high. done_ok_o or err_o holds until the next start. At most one of busy_o, done_ok_o and err_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a configuration run (taken only when not busy) |
| payload_len_i | input | LEN_W | Number of bitstream bytes, sampled at start |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Bitstream byte available |
| s_ready_o | output | 1 | Loader accepts a bitstream byte this cycle |
| prog_n_o | output | 1 | Target program pin, active low |
| cs_n_o | output | 1 | Target chip select, active low |
| wr_n_o | output | 1 | Target write enable, active low |
| cclk_o | output | 1 | Target configuration clock |
| d_o | output | 8 | Target data bus, bit-reversed byte |
| init_i | input | 1 | Target init status pin |
| done_i | input | 1 | Target done status pin |
| busy_o | output | 1 | Sequence in progress |
| done_ok_o | output | 1 | Last run ended with done high |
| err_o | output | 1 | Last run ended in an error |
| err_code_o | output | 3 | 0 none, 1 done did not fall, 2 init did not rise, 3 finish timeout, 4 init fell after data |

## Verification
The hardest cases to reach from the ports are the four failure exits. They need a target that misbehaves at one precise step while behaving correctly at every earlier one. The bench therefore models the target as a small state machine with a selectable fault mode: done stuck high, init never rising, no reply after the tail, or init dropping after the tail. Each run then takes one exit, and the bench checks its code and the exact length of the busy window. Stream stalls during the payload are produced by a periodic gap on s_valid_i. A start pulse injected mid-run tests that start is ignored while busy.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG_LO,
    ST_PROG_REL,
    ST_PRE,
    ST_PAY,
    ST_POST,
    ST_WAIT_FIN,
    ST_OK,
    ST_ERR
  } ld_state_t;

  localparam logic [2:0] EC_NONE      = 3'd0;
  localparam logic [2:0] EC_PROG_ACK  = 3'd1;
  localparam logic [2:0] EC_INIT_RISE = 3'd2;
  localparam logic [2:0] EC_FIN_TMO   = 3'd3;
  localparam logic [2:0] EC_CFG_FAULT = 3'd4;

  localparam logic [7:0] FILL_HEAD = 8'hFF;
  localparam logic [7:0] FILL_TAIL = 8'h00;

  // bits needed for a counter that runs 0 .. n-1
  function automatic int cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic logic in_data_phase(input ld_state_t s);
    return (s == ST_PRE) || (s == ST_PAY) || (s == ST_POST);
  endfunction

  function automatic logic is_pin_wait(input ld_state_t s);
    return (s == ST_PROG_LO) || (s == ST_PROG_REL) || (s == ST_WAIT_FIN);
  endfunction

  function automatic logic is_rest(input ld_state_t s);
    return (s == ST_IDLE) || (s == ST_OK) || (s == ST_ERR);
  endfunction

endpackage

// File: rtl/cfg_ld_tmo.sv
module cfg_ld_tmo
  import cfg_loader_pkg::*;
#(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int TW = cnt_width(LIMIT);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == LAST);

  AST_TMO_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R9
endmodule

// File: rtl/cfg_ld_cclk.sv
module cfg_ld_cclk
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CCLK_LO = 2,
  parameter int unsigned CCLK_HI = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       cclk_o,
  output logic [7:0] pins_o,
  output logic       active_o,
  output logic       byte_done_o
);
  localparam int unsigned PMAX = (CCLK_LO > CCLK_HI) ? CCLK_LO : CCLK_HI;
  localparam int PW = cnt_width(PMAX);
  localparam logic [PW-1:0] LO_LAST = PW'(CCLK_LO - 1);
  localparam logic [PW-1:0] HI_LAST = PW'(CCLK_HI - 1);

  logic          active_q, cclk_q;
  logic [PW-1:0] ph_q;
  logic [7:0]    pins_q;
  logic [7:0]    swapped;

  // most significant bit of the byte lands on lane 0
  for (genvar i = 0; i < 8; i++) begin : g_lane
    assign swapped[i] = byte_i[7-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cclk_q   <= 1'b1;
      ph_q     <= '0;
      pins_q   <= '0;
    end else if (load_i && !active_q) begin
      active_q <= 1'b1;
      cclk_q   <= 1'b0;
      ph_q     <= '0;
      pins_q   <= swapped;
    end else if (active_q) begin
      if (!cclk_q) begin
        if (ph_q == LO_LAST) begin
          cclk_q <= 1'b1;
          ph_q   <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end else begin
        if (ph_q == HI_LAST) begin
          active_q <= 1'b0;
          ph_q     <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign cclk_o      = cclk_q;
  assign pins_o      = pins_q;
  assign active_o    = active_q;
  assign byte_done_o = active_q && cclk_q && (ph_q == HI_LAST);

  AST_PINS_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o && $past(cclk_o)) |-> $stable(pins_o)); // R3
  AST_LOW_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_o |-> active_o); // R3
endmodule

// File: rtl/cfg_ld_seq.sv
module cfg_ld_seq
  import cfg_loader_pkg::*;
#(
  parameter int unsigned PAD_BYTES = 64,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  input  logic             init_i,
  input  logic             done_i,
  input  logic             slot_busy_i,
  input  logic             byte_done_i,
  input  logic             tmo_hit_i,
  output logic             s_ready_o,
  output logic             load_o,
  output logic [7:0]       load_byte_o,
  output ld_state_t        state_o,
  output logic             state_chg_o,
  output logic             wait_o,
  output logic [2:0]       err_code_o
);
  localparam logic [LEN_W-1:0] PAD_L = LEN_W'(PAD_BYTES);

  ld_state_t        state_q, state_d;
  logic [2:0]       err_q, err_d;
  logic [LEN_W-1:0] cnt_q, len_q, target;
  logic             data_ph, phase_end, rest;

  assign rest      = is_rest(state_q);
  assign data_ph   = in_data_phase(state_q);
  assign target    = (state_q == ST_PAY) ? len_q : PAD_L;
  assign phase_end = data_ph && !slot_busy_i && (cnt_q == target);

  assign s_ready_o   = (state_q == ST_PAY) && !slot_busy_i && !phase_end;
  assign load_o      = data_ph && !slot_busy_i && !phase_end &&
                       ((state_q != ST_PAY) || s_valid_i);
  assign load_byte_o = (state_q == ST_PAY) ? s_data_i :
                       (state_q == ST_PRE) ? FILL_HEAD : FILL_TAIL;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE, ST_OK, ST_ERR: begin
        if (start_i) begin
          state_d = ST_PROG_LO;
          err_d   = EC_NONE;
        end
      end
      ST_PROG_LO: begin
        if (!done_i) state_d = ST_PROG_REL;
        else if (tmo_hit_i) begin
          state_d = ST_ERR;
          err_d   = EC_PROG_ACK;
        end
      end
      ST_PROG_REL: begin
        if (init_i) state_d = ST_PRE;
        else if (tmo_hit_i) begin
          state_d = ST_ERR;
          err_d   = EC_INIT_RISE;
        end
      end
      ST_PRE:  if (phase_end) state_d = ST_PAY;
      ST_PAY:  if (phase_end) state_d = ST_POST;
      ST_POST: if (phase_end) state_d = ST_WAIT_FIN;
      ST_WAIT_FIN: begin
        if (done_i) state_d = ST_OK;
        else if (!init_i) begin
          state_d = ST_ERR;
          err_d   = EC_CFG_FAULT;
        end else if (tmo_hit_i) begin
          state_d = ST_ERR;
          err_d   = EC_FIN_TMO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= EC_NONE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (rest && start_i) len_q <= len_i;
      if (state_d != state_q) cnt_q <= '0;
      else if (byte_done_i)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o     = state_q;
  assign state_chg_o = (state_d != state_q);
  assign wait_o      = is_pin_wait(state_q);
  assign err_code_o  = err_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    data_ph |-> (cnt_q <= target)); // R6
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rest && $past(!rest)) |-> $stable(len_q)); // R10
endmodule

// File: rtl/sp_cfg_loader.sv
module sp_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned PAD_BYTES  = 64,
  parameter int unsigned CCLK_LO    = 2,
  parameter int unsigned CCLK_HI    = 2,
  parameter int unsigned TMO_CYCLES = 100000,
  parameter int unsigned LEN_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] payload_len_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             prog_n_o,
  output logic             cs_n_o,
  output logic             wr_n_o,
  output logic             cclk_o,
  output logic [7:0]       d_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             done_ok_o,
  output logic             err_o,
  output logic [2:0]       err_code_o
);
  ld_state_t  state;
  logic       load, slot_busy, byte_done, tmo_hit, state_chg, in_wait;
  logic [7:0] load_byte;

  cfg_ld_seq #(.PAD_BYTES(PAD_BYTES), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(payload_len_i),
    .s_data_i(s_data_i), .s_valid_i(s_valid_i), .init_i(init_i), .done_i(done_i),
    .slot_busy_i(slot_busy), .byte_done_i(byte_done), .tmo_hit_i(tmo_hit),
    .s_ready_o(s_ready_o), .load_o(load), .load_byte_o(load_byte),
    .state_o(state), .state_chg_o(state_chg), .wait_o(in_wait),
    .err_code_o(err_code_o)
  );

  cfg_ld_cclk #(.CCLK_LO(CCLK_LO), .CCLK_HI(CCLK_HI)) u_cclk (
    .clk(clk), .rst_n(rst_n), .load_i(load), .byte_i(load_byte),
    .cclk_o(cclk_o), .pins_o(d_o), .active_o(slot_busy), .byte_done_o(byte_done)
  );

  cfg_ld_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run_i(in_wait), .clr_i(state_chg), .hit_o(tmo_hit)
  );

  assign prog_n_o  = (state != ST_PROG_LO);
  assign cs_n_o    = !in_data_phase(state);
  assign wr_n_o    = !in_data_phase(state);
  assign busy_o    = !is_rest(state);
  assign done_ok_o = (state == ST_OK);
  assign err_o     = (state == ST_ERR);

  AST_DATA_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(init_i) && prog_n_o)); // R2
  AST_PROG_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (cs_n_o && cclk_o)); // R2
  AST_READY_IN_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (!cs_n_o && !wr_n_o && cclk_o)); // R7
  AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok_o) |-> $past(done_i)); // R8
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (err_code_o != 3'd0)); // R9
endmodule

// File: tb/test_sp_cfg_loader.sv
module test_sp_cfg_loader;
  localparam int PAD = 4;
  localparam int LO  = 2;
  localparam int HI  = 1;
  localparam int TMO = 24;
  localparam int LW  = 12;

  localparam int M_OK = 0, M_STUCK = 1, M_NOINIT = 2, M_NOFIN = 3, M_INITERR = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] len_in = '0;
  logic [7:0] s_data, d_o;
  logic s_valid, s_ready, prog_n, cs_n, wr_n, cclk, busy, ok, err;
  logic [2:0] code;
  logic init_dev = 1'b1, done_dev = 1'b1;

  int tests = 0, fails = 0, cycles = 0;
  int mode = M_OK;
  int src_len = 0, src_mul = 1, src_add = 0, src_cnt = 0, src_base = 0;
  bit src_on = 1'b0, gaps = 1'b0;
  logic [1:0] gap_ph = '0;
  logic [7:0] cap [4096];
  int cap_n = 0, del = 0, fin_cnt = 0;
  logic prev_cclk = 1'b1, prev_cs = 1'b1;
  int src_idx;

  always #5 clk = ~clk;

  sp_cfg_loader #(.PAD_BYTES(PAD), .CCLK_LO(LO), .CCLK_HI(HI), .TMO_CYCLES(TMO),
                  .LEN_W(LW)) i_sp_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .payload_len_i(len_in),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .prog_n_o(prog_n), .cs_n_o(cs_n), .wr_n_o(wr_n), .cclk_o(cclk), .d_o(d_o),
    .init_i(init_dev), .done_i(done_dev), .busy_o(busy), .done_ok_o(ok),
    .err_o(err), .err_code_o(code));

  function automatic logic [7:0] pay_byte(input int k);
    return 8'((k * src_mul + src_add) % 256);
  endfunction

  // expected lane pattern: value of bit j moves to weight 2**(7-j)
  function automatic logic [7:0] lanes(input logic [7:0] b);
    int v = 0;
    for (int j = 0; j < 8; j++) if ((int'(b) / (1 << j)) % 2 == 1) v += 1 << (7 - j);
    return 8'(v);
  endfunction

  assign src_idx = src_cnt - src_base;
  assign s_valid = src_on && (src_idx < src_len) && !(gaps && gap_ph == 2'd0);
  assign s_data  = pay_byte(src_idx);

  // target model and stream source
  always @(posedge clk) begin
    cycles   <= cycles + 1;
    gap_ph   <= gap_ph + 2'd1;
    prev_cclk <= cclk;
    prev_cs  <= cs_n;
    if (s_valid && s_ready) src_cnt <= src_cnt + 1;
    if (cclk && !prev_cclk && !cs_n && !wr_n) begin
      cap[cap_n % 4096] <= d_o;
      cap_n <= cap_n + 1;
    end
    if (!prog_n) begin
      init_dev <= 1'b0;
      del <= 0;
      if (mode != M_STUCK) done_dev <= 1'b0;
    end else if (!init_dev && fin_cnt == 0 && mode != M_NOINIT) begin
      if (del == 3) init_dev <= 1'b1;
      else del <= del + 1;
    end
    if (cs_n && !prev_cs) fin_cnt <= 1;
    else if (fin_cnt == 4) begin
      fin_cnt <= 0;
      if (mode == M_OK) done_dev <= 1'b1;
      if (mode == M_INITERR) init_dev <= 1'b0;
    end else if (fin_cnt > 0) fin_cnt <= fin_cnt + 1;
  end

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input int len, input int mul, input int add, input bit gp,
                         input int md, input bit poke, input int exp_code);
    int base_cap, busy_n, low_n, excl_bad, rdy_bad, ord_bad, cyc, nbytes;
    int bad_head, bad_pay, bad_tail;
    bit saw_prog;
    mode = md; src_len = len; src_mul = mul; src_add = add; gaps = gp;
    src_base = src_cnt; base_cap = cap_n; len_in = LW'(len); src_on = 1'b1;
    busy_n = 0; low_n = 0; excl_bad = 0; rdy_bad = 0; ord_bad = 0; cyc = 0;
    saw_prog = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy && cyc < 20000) begin
      busy_n++;
      if (!cclk) low_n++;
      if (int'(busy) + int'(ok) + int'(err) > 1) excl_bad++;
      if (s_ready && cs_n) rdy_bad++;
      if (!prog_n) saw_prog = 1'b1;
      if (!cs_n && (!saw_prog || !prog_n)) ord_bad++;
      start = poke && (cyc == 40);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc < 20000, "R10", "run ended", cyc, 0);
    chk(excl_bad == 0 && (int'(ok) + int'(err) == 1), "R10", "one status", excl_bad, 0);
    chk(rdy_bad == 0, "R7", "ready outside payload", rdy_bad, 0);
    chk(ord_bad == 0, "R2", "data before reset handshake", ord_bad, 0);
    chk(int'(code) == exp_code, (exp_code == 4) ? "R8" : "R9", "error code",
        int'(code), exp_code);
    chk(ok == (exp_code == 0), "R8", "done_ok", int'(ok), int'(exp_code == 0));
    if (md == M_STUCK) chk(busy_n == TMO, "R9", "busy window", busy_n, TMO);
    if (md == M_OK || md == M_NOFIN || md == M_INITERR) begin
      nbytes = cap_n - base_cap;
      chk(nbytes == 2 * PAD + len, "R6", "byte count", nbytes, 2 * PAD + len);
      chk(low_n == (2 * PAD + len) * LO, "R3", "cclk low cycles", low_n,
          (2 * PAD + len) * LO);
      chk(cs_n && wr_n, "R8", "select released", int'(cs_n), 1);
      bad_head = 0; bad_pay = 0; bad_tail = 0;
      for (int k = 0; k < PAD; k++) begin
        if (cap[(base_cap + k) % 4096] != 8'hFF) bad_head++;
        if (cap[(base_cap + PAD + len + k) % 4096] != 8'h00) bad_tail++;
      end
      for (int k = 0; k < len; k++)
        if (cap[(base_cap + PAD + k) % 4096] != lanes(pay_byte(k))) bad_pay++;
      chk(bad_head == 0 && bad_tail == 0, "R4", "fill bytes", bad_head + bad_tail, 0);
      chk(bad_pay == 0, "R5", "payload lanes", bad_pay, 0);
    end
    src_on = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prog_n && cs_n && wr_n && cclk, "R1", "idle pins", int'({prog_n, cs_n, wr_n, cclk}), 15);
    chk(!busy && !ok && !err && !s_ready, "R1", "idle status",
        int'({busy, ok, err, s_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(prog_n && cs_n && !busy, "R1", "after reset release", int'({prog_n, cs_n, busy}), 6);

    // every byte value once, in order
    run_cfg(256, 1, 0, 1'b0, M_OK, 1'b0, 0);
    // single 0xAA byte lands as 8'h55
    run_cfg(1, 0, 170, 1'b0, M_OK, 1'b0, 0);
    chk(cap[(cap_n - PAD - 1) % 4096] == 8'h55, "R5", "0xAA lanes",
        int'(cap[(cap_n - PAD - 1) % 4096]), 85);
    // short lengths with and without stream stalls, R6 R7
    for (int l = 0; l < 6; l++)
      for (int g = 0; g < 2; g++) run_cfg(l, 37, 11 + l, g[0], M_OK, 1'b0, 0);
    // start while busy is ignored, R10
    run_cfg(20, 5, 3, 1'b1, M_OK, 1'b1, 0);
    repeat (10) @(negedge clk);
    chk(ok && !busy, "R10", "status held", int'({ok, busy}), 2);
    // failure exits, R8 R9
    run_cfg(3, 7, 1, 1'b0, M_STUCK, 1'b0, 1);
    run_cfg(3, 7, 1, 1'b0, M_NOINIT, 1'b0, 2);
    run_cfg(3, 7, 1, 1'b0, M_NOFIN, 1'b0, 3);
    run_cfg(3, 7, 1, 1'b0, M_INITERR, 1'b0, 4);
    repeat (10) @(negedge clk);
    chk(err && int'(code) == 4, "R10", "error held", int'(code), 4);
    // recovery after an error
    run_cfg(2, 9, 4, 1'b0, M_OK, 1'b0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end
endmodule